// File: doc/BRIEF.md
# Dual-Channel Phase Detector with Lock Monitor

This block serves two frequency-synthesis loops, a low band (channel 0) and a high band (channel 1). Each loop supplies a divided reference pulse `fr` and a divided oscillator pulse `fp`. Both pulses are synchronous to the oscillator clock that also times the lock windows.

For each channel, a phase-frequency detector turns the order of the rising edges into a pair of drive requests. The pair encodes a three-state charge-pump control: drive high, drive low, or float. A polarity input swaps the sense of the two drives. When the edges meet, both requests overlap for one clock, so a near-zero error still yields a pulse and there is no dead zone.

A lock judge per channel counts the clocks during which only one request is active. A large error drops the channel's lock at once. Lock returns only after several consecutive small errors. The combined lock is the AND of both channels. A sleeping channel counts as locked, and its drive is held floating.

One shared monitor output shows either the combined lock or one of the four raw divided pulses.

Top module: `dual_pfd_lock`

## Requirements
- R1: When `fr` rises before `fp` on a channel, only the "up" request is active, from the clock after the `fr` rise until the `fp` rise. With `pol_i`=1 that request appears on `drive_hi_o`; with `pol_i`=0 it appears on `drive_lo_o`.
- R2: When `fp` rises before `fr`, only the "down" request is active. With `pol_i`=1 it appears on `drive_lo_o`; with `pol_i`=0 it appears on `drive_hi_o`.
- R3: When the second edge arrives, both drive outputs of the channel are high for exactly one clock. After that both are low, which is the float state. Coincident edges give a single such one-clock overlap.
- R4: If the first edge is sampled at clock k and the second at clock k+d, the leading request is high for d+1 clocks, ending with the overlap clock.
- R5: A channel's lock drops one clock after its running error count reaches UNLOCK_CYC (default 16). This happens even before the lagging edge arrives. An error of UNLOCK_CYC-1 clocks does not drop lock.
- R6: Lock rises on the clock after the CONFIRM_CNT-th (default 3) consecutive comparison whose error is below LOCK_CYC (default 8). An error from LOCK_CYC to UNLOCK_CYC-1 restarts the confirmation count and leaves the current lock state unchanged.
- R7: `lock_o` is the AND over the channels of (channel lock OR `sleep_i`). With both channels asleep, `lock_o` is 1.
- R8: While `sleep_i` is high, both drive outputs of the channel are 0 in the same cycle, and the channel's lock, confirmation count and pending requests are cleared. After wake-up, `fp` rises are ignored until the first `fr` rise. The same holds after reset.
- R9: With `mon_sel_i`=1, `mon_o` follows `tap_sel_i`: 0 gives `fr_i[0]`, 1 gives `fr_i[1]`, 2 gives `fp_i[0]`, 3 gives `fp_i[1]`. With `mon_sel_i`=0, `mon_o` equals `lock_o`.
- R10: After reset, all drive outputs are 0, and `lock_o` is 0 while any channel is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fr_i | input | 2 | Divided reference pulse per channel |
| fp_i | input | 2 | Divided oscillator pulse per channel |
| pol_i | input | 2 | Drive polarity per channel |
| sleep_i | input | 2 | Power-save per channel, active high |
| mon_sel_i | input | 1 | 1: monitor shows a tap, 0: shows lock |
| tap_sel_i | input | 2 | Monitor tap selector |
| drive_hi_o | output | 2 | Charge pump drive-high request |
| drive_lo_o | output | 2 | Charge pump drive-low request |
| lock_o | output | 1 | Combined lock |
| mon_o | output | 1 | Shared monitor output |

## Verification
The bench uses the default parameters: LOCK_CYC=8, UNLOCK_CYC=16 and CONFIRM_CNT=3. With these values, every window boundary is reachable with edge offsets of at most 20 clocks. The offsets 7 and 8 straddle the lock window, and 15 and 16 straddle the unlock window. One channel is put to sleep so that `lock_o` exposes the other channel's lock directly. Both polarities are covered, because channel 0 runs with `pol_i`=1 and channel 1 with `pol_i`=0.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    TAP_FR_LO = 2'd0,
    TAP_FR_HI = 2'd1,
    TAP_FP_LO = 2'd2,
    TAP_FP_HI = 2'd3
  } tap_e;
endpackage

// File: rtl/pfd_edge_core.sv
module pfd_edge_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fr_i,
  input  logic fp_i,
  input  logic sleep_i,
  output logic up_o,
  output logic dn_o
);
  logic fr_d, fp_d, armed_q;
  logic fr_rise, fp_rise;

  assign fr_rise = fr_i & ~fr_d;
  // fp edges only count once an fr edge has opened the detector
  assign fp_rise = fp_i & ~fp_d & (armed_q | fr_rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_d    <= 1'b0;
      fp_d    <= 1'b0;
      armed_q <= 1'b0;
      up_o    <= 1'b0;
      dn_o    <= 1'b0;
    end else begin
      fr_d <= fr_i;
      fp_d <= fp_i;
      if (sleep_i) begin
        armed_q <= 1'b0;
        up_o    <= 1'b0;
        dn_o    <= 1'b0;
      end else begin
        armed_q <= armed_q | fr_rise;
        if (up_o && dn_o) begin
          up_o <= fr_rise;
          dn_o <= fp_rise;
        end else begin
          up_o <= up_o | fr_rise;
          dn_o <= dn_o | fp_rise;
        end
      end
    end
  end
endmodule

// File: rtl/pfd_lock_judge.sv
module pfd_lock_judge #(
  parameter int LOCK_CYC    = 8,
  parameter int UNLOCK_CYC  = 16,
  parameter int CONFIRM_CNT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic dn_i,
  input  logic sleep_i,
  output logic lock_o
);
  localparam int CW = $clog2(UNLOCK_CYC + 1);
  localparam int GW = $clog2(CONFIRM_CNT + 1);

  logic [CW-1:0] err_q;
  logic [GW-1:0] good_q;
  logic          close_w;

  assign close_w = up_i & dn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
    end else if (sleep_i || close_w) begin
      err_q <= '0;
    end else if ((up_i ^ dn_i) && err_q != CW'(UNLOCK_CYC)) begin
      err_q <= err_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o <= 1'b0;
      good_q <= '0;
    end else if (sleep_i || err_q == CW'(UNLOCK_CYC)) begin
      lock_o <= 1'b0;
      good_q <= '0;
    end else if (close_w) begin
      if (err_q < CW'(LOCK_CYC)) begin
        if (good_q == GW'(CONFIRM_CNT - 1)) lock_o <= 1'b1;
        if (good_q != GW'(CONFIRM_CNT)) good_q <= good_q + 1'b1;
      end else begin
        good_q <= '0;
      end
    end
  end
endmodule

// File: rtl/pfd_mon_mux.sv
module pfd_mon_mux
  import pfd_pkg::*;
(
  input  logic [NUM_CH-1:0] fr_i,
  input  logic [NUM_CH-1:0] fp_i,
  input  logic              mon_sel_i,
  input  logic [1:0]        tap_sel_i,
  input  logic              lock_i,
  output logic              mon_o
);
  logic tap_w;

  always_comb begin
    unique case (tap_e'(tap_sel_i))
      TAP_FR_LO: tap_w = fr_i[0];
      TAP_FR_HI: tap_w = fr_i[1];
      TAP_FP_LO: tap_w = fp_i[0];
      default:   tap_w = fp_i[1];
    endcase
  end

  assign mon_o = mon_sel_i ? tap_w : lock_i;
endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock
  import pfd_pkg::*;
#(
  parameter int LOCK_CYC    = 8,
  parameter int UNLOCK_CYC  = 16,
  parameter int CONFIRM_CNT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] fr_i,
  input  logic [NUM_CH-1:0] fp_i,
  input  logic [NUM_CH-1:0] pol_i,
  input  logic [NUM_CH-1:0] sleep_i,
  input  logic              mon_sel_i,
  input  logic [1:0]        tap_sel_i,
  output logic [NUM_CH-1:0] drive_hi_o,
  output logic [NUM_CH-1:0] drive_lo_o,
  output logic              lock_o,
  output logic              mon_o
);
  logic [NUM_CH-1:0] up_w, dn_w, lock_ch;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pfd_edge_core i_core (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fr_i   (fr_i[c]),
      .fp_i   (fp_i[c]),
      .sleep_i(sleep_i[c]),
      .up_o   (up_w[c]),
      .dn_o   (dn_w[c])
    );

    pfd_lock_judge #(
      .LOCK_CYC   (LOCK_CYC),
      .UNLOCK_CYC (UNLOCK_CYC),
      .CONFIRM_CNT(CONFIRM_CNT)
    ) i_judge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .up_i   (up_w[c]),
      .dn_i   (dn_w[c]),
      .sleep_i(sleep_i[c]),
      .lock_o (lock_ch[c])
    );

    assign drive_hi_o[c] = ~sleep_i[c] & (pol_i[c] ? up_w[c] : dn_w[c]);
    assign drive_lo_o[c] = ~sleep_i[c] & (pol_i[c] ? dn_w[c] : up_w[c]);
  end

  assign lock_o = &(lock_ch | sleep_i);

  pfd_mon_mux i_mon (
    .fr_i     (fr_i),
    .fp_i     (fp_i),
    .mon_sel_i(mon_sel_i),
    .tap_sel_i(tap_sel_i),
    .lock_i   (lock_o),
    .mon_o    (mon_o)
  );
endmodule

// File: rtl/dual_pfd_lock_chk.sv
module dual_pfd_lock_chk #(
  parameter int NCH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] sleep_i,
  input logic [NCH-1:0] drive_hi_o,
  input logic [NCH-1:0] drive_lo_o,
  input logic           lock_o,
  input logic [NCH-1:0] up_w,
  input logic [NCH-1:0] dn_w,
  input logic [NCH-1:0] lock_ch
);
  for (genvar c = 0; c < NCH; c++) begin : g_prop
    p_overlap_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drive_hi_o[c] && drive_lo_o[c]) |=> !(drive_hi_o[c] && drive_lo_o[c]));

    p_sleep_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_i[c] |-> (!drive_hi_o[c] && !drive_lo_o[c]));

    p_lock_rise_on_close_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lock_ch[c]) |-> $past(up_w[c] && dn_w[c]));

    p_lock_fall_on_error_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(lock_ch[c]) && !$past(sleep_i[c])) |-> $past(up_w[c] || dn_w[c]));
  end

  p_all_asleep_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&sleep_i) |-> lock_o);
endmodule

bind dual_pfd_lock dual_pfd_lock_chk #(.NCH(pfd_pkg::NUM_CH)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sleep_i   (sleep_i),
  .drive_hi_o(drive_hi_o),
  .drive_lo_o(drive_lo_o),
  .lock_o    (lock_o),
  .up_w      (up_w),
  .dn_w      (dn_w),
  .lock_ch   (lock_ch)
);

// File: tb/test_dual_pfd_lock.sv
module test_dual_pfd_lock;
  typedef struct {
    int         cyc;
    logic [5:0] mask;
    logic [5:0] val;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] fr = '0, fp = '0, pol = 2'b01, sleep = '0, tap = '0;
  logic       mon_sel = 1'b0;
  logic [1:0] drive_hi, drive_lo;
  logic       lock, mon;

  int   cyc_cnt = 0;
  int   n_chk = 0, n_fail = 0;
  int   lk [2];
  int   good [2];
  exp_t exp_q [$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  dual_pfd_lock i_dual_pfd_lock (
    .clk_i(clk), .rst_ni(rst_ni), .fr_i(fr), .fp_i(fp), .pol_i(pol),
    .sleep_i(sleep), .mon_sel_i(mon_sel), .tap_sel_i(tap),
    .drive_hi_o(drive_hi), .drive_lo_o(drive_lo), .lock_o(lock), .mon_o(mon)
  );

  // monitor: compare all items due this cycle
  always @(negedge clk) begin
    logic [5:0] obs;
    obs = {lock, mon, drive_hi, drive_lo};
    if (rst_ni) begin
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
        if (exp_q[i].cyc <= cyc_cnt) begin
          n_chk++;
          if (exp_q[i].cyc < cyc_cnt || (obs & exp_q[i].mask) != (exp_q[i].val & exp_q[i].mask)) begin
            n_fail++;
            $display("FAIL %s cyc %0d: actual %b expected %b mask %b",
                     exp_q[i].req, exp_q[i].cyc, obs & exp_q[i].mask,
                     exp_q[i].val & exp_q[i].mask, exp_q[i].mask);
          end
          exp_q.delete(i);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(int c, logic [5:0] m, logic [5:0] v, string r);
    exp_t e;
    e.cyc = c; e.mask = m; e.val = v; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic push_cp(int c, int ch, bit up, bit dn, string r);
    bit hi, lo;
    hi = pol[ch] ? up : dn;
    lo = pol[ch] ? dn : up;
    push(c, 6'((1 << (2 + ch)) | (1 << ch)),
         6'((int'(hi) << (2 + ch)) | (int'(lo) << ch)), r);
  endtask

  task automatic push_lock(int c, bit v, string r);
    push(c, 6'b100000, {v, 5'b0}, r);
  endtask

  task automatic push_mon(int c, bit v, string r);
    push(c, 6'b010000, {1'b0, v, 4'b0}, r);
  endtask

  // one comparison: d >= 0 means fr leads by d clocks, d < 0 means fp leads
  task automatic run_pair(int ch, int d, bit chk_lock, string r);
    int  a  = (d < 0) ? -d : d;
    int  n0 = cyc_cnt;
    bit  frf = (d >= 0);
    for (int k = 1; k <= a; k++) push_cp(n0 + k, ch, frf, !frf, r);
    push_cp(n0 + a + 1, ch, 1, 1, r);
    push_cp(n0 + a + 2, ch, 0, 0, r);
    if (chk_lock) begin
      if (a >= 16) begin
        push_lock(n0 + 17, lk[ch] != 0, r);
        lk[ch] = 0; good[ch] = 0;
        push_lock(n0 + 18, 0, r);
        push_lock(n0 + a + 2, 0, r);
      end else begin
        push_lock(n0 + a + 1, lk[ch] != 0, r);
        if (a < 8) begin
          if (good[ch] < 3) good[ch]++;
          if (good[ch] >= 3) lk[ch] = 1;
        end else begin
          good[ch] = 0;
        end
        push_lock(n0 + a + 2, lk[ch] != 0, r);
      end
    end
    if (d == 0) begin
      fr[ch] = 1'b1; fp[ch] = 1'b1;
    end else if (frf) fr[ch] = 1'b1;
    else fp[ch] = 1'b1;
    for (int i = 1; i <= a; i++) begin
      step();
      if (i == a) begin
        fr[ch] = 1'b1; fp[ch] = 1'b1;
      end
    end
    step(); step(); step();
    fr[ch] = 1'b0; fp[ch] = 1'b0;
    step(); step();
  endtask

  initial begin
    lk[0] = 0; lk[1] = 0; good[0] = 0; good[1] = 0;
    fork
      begin
        repeat (3) step();
        rst_ni = 1'b1;
        step();
        push(cyc_cnt, 6'b111111, 6'b000000, "R10 reset state");
        step();
        sleep = 2'b10;
        step();
        // channel 0, pol 1
        run_pair(0, 3, 1, "R1 R4 fr leads by 3");
        run_pair(0, 0, 1, "R3 coincident edges");
        run_pair(0, -2, 1, "R2 fp leads by 2");
        run_pair(0, 10, 1, "R6 mid error keeps lock");
        run_pair(0, 20, 1, "R5 large error unlocks");
        run_pair(0, 1, 1, "R6 confirm 1");
        run_pair(0, -1, 1, "R6 confirm 2");
        run_pair(0, 7, 1, "R6 confirm 3 at LOCK-1");
        run_pair(0, 8, 1, "R6 error at LOCK restarts count");
        run_pair(0, 15, 1, "R5 error UNLOCK-1 keeps lock");
        run_pair(0, 16, 1, "R5 error UNLOCK drops lock");
        // channel 1, pol 0, channel 0 asleep
        sleep = 2'b01;
        lk[0] = 0; good[0] = 0;
        push_cp(cyc_cnt, 0, 0, 0, "R8 sleeping channel floats");
        step();
        fp[1] = 1'b1;
        for (int k = 1; k <= 4; k++) push_cp(cyc_cnt + k, 1, 0, 0, "R8 fp before first fr ignored");
        repeat (4) step();
        fp[1] = 1'b0;
        step(); step();
        run_pair(1, 4, 1, "R1 pol 0 fr leads");
        run_pair(1, -3, 1, "R2 pol 0 fp leads");
        run_pair(1, 2, 1, "R6 channel 1 locks");
        sleep = 2'b00;
        push_lock(cyc_cnt, 0, "R7 AND with unlocked channel");
        step();
        sleep = 2'b11;
        push_lock(cyc_cnt, 1, "R7 both asleep");
        step();
        sleep = 2'b01;
        lk[1] = 0; good[1] = 0;
        push_lock(cyc_cnt, 0, "R8 sleep clears lock");
        step();
        fr[1] = 1'b1;
        push_cp(cyc_cnt + 1, 1, 1, 0, "R8 request before sleep");
        step(); step();
        sleep[1] = 1'b1;
        push_cp(cyc_cnt, 1, 0, 0, "R8 sleep floats at once");
        step();
        fr[1] = 1'b0;
        step();
        sleep[1] = 1'b0;
        push_cp(cyc_cnt + 1, 1, 0, 0, "R8 no pending request after wake");
        step(); step();
        // monitor
        sleep = 2'b11;
        mon_sel = 1'b0;
        push_mon(cyc_cnt, 1, "R9 lock shown when deselected");
        step();
        mon_sel = 1'b1;
        for (int p = 0; p < 2; p++) begin
          fr = (p == 0) ? 2'b01 : 2'b10;
          fp = (p == 0) ? 2'b10 : 2'b01;
          for (int t = 0; t < 4; t++) begin
            tap = 2'(t);
            push_mon(cyc_cnt, t[1] ? fp[t[0]] : fr[t[0]], "R9 tap select");
            step();
          end
        end
        repeat (5) step();
      end
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    if (exp_q.size() != 0) begin
      n_fail += exp_q.size();
      $display("FAIL pending: actual %0d items left expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule